// File: doc/BRIEF.md
# Checkerboard LUT Cell Array

A rectangular array of identical logic cells, each exchanging one bit with each of its four neighbours. Every cell stores a 64-bit program that holds sixteen 4-bit output patterns. The cell's current 4-bit input state picks one pattern, which becomes its new 4-bit output. The input state is the bit each neighbour aims at it. The array is clocked in two alternating colour phases laid out like a chessboard. While one colour updates, the other colour holds still, so no cell ever reads a neighbour that is changing in the same phase.

A controller advances the array one phase per `step_i` pulse and counts whole two-phase cycles. A write port loads a new program into any single cell at any time. Bits that enter the array at its border come from four edge input vectors. Bits that cells aim off the array appear on four edge output vectors.

Top module: `lut_grid`

## Requirements
- R1: On evaluation a cell's new output nibble is `prog[4*s+3 : 4*s]`, where `s` is its 4-bit input state, so pattern 0 sits in the least significant hex digit of the program.
- R2: In both input and output nibbles, bit 0 faces up (row y-1), bit 1 faces right (column x+1), bit 2 faces below (row y+1) and bit 3 faces left (column x-1). A cell's input bit for a direction is the output bit that the adjacent cell aims back at it. For example, the up input of (x,y) is bit 2 of (x,y-1).
- R3: Border inputs are taken from `edge_up_i[x]` (row 0 up), `edge_dn_i[x]` (last row below), `edge_lf_i[y]` (column 0 left) and `edge_rt_i[y]` (last column right). The outputs `edge_up_o[x]`, `edge_dn_o[x]`, `edge_lf_o[y]` and `edge_rt_o[y]` show the output bits of the border cells that point off the array.
- R4: A step taken with `phase_o`=0 updates only the cells with even x+y. A step taken with `phase_o`=1 updates only the cells with odd x+y. The other cells keep their outputs.
- R5: Each `step_i` pulse runs exactly one phase and flips `phase_o`. In a cycle without `step_i`, no cell output, `phase_o` or `cycle_o` changes, whatever the edge inputs or program writes do.
- R6: `cycle_o` increments by one, wrapping at its width, on each step taken with `phase_o`=1, and holds on steps taken with `phase_o`=0.
- R7: After reset all cell outputs are 0, `phase_o`=0 and `cycle_o`=0. Every program equals 0xFB73EA62D951C840 when `PASS_DEFAULT`=1, and all zeros when `PASS_DEFAULT`=0.
- R8: `prog_we_i` with `prog_addr_i` = y*COLS+x replaces the program of cell (x,y). If the write falls in the same cycle as a step that evaluates that cell, the evaluation still uses the old program, and the new one is used from the next evaluation on. Addresses at or above COLS*ROWS change nothing.
- R9: Program 0xFEDCBA9876543210 sends each input bit back out in the same direction it arrived from. Program 0xFB73EA62D951C840 sends it out the opposite side, so an input from up leaves toward below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Run one evaluation phase |
| prog_we_i | input | 1 | Program write strobe |
| prog_addr_i | input | ADDR_W | Cell index y*COLS+x |
| prog_data_i | input | 64 | New program word |
| edge_up_i | input | COLS | Up inputs of row 0 |
| edge_dn_i | input | COLS | Below inputs of the last row |
| edge_lf_i | input | ROWS | Left inputs of column 0 |
| edge_rt_i | input | ROWS | Right inputs of the last column |
| edge_up_o | output | COLS | Up outputs of row 0 |
| edge_dn_o | output | COLS | Below outputs of the last row |
| edge_lf_o | output | ROWS | Left outputs of column 0 |
| edge_rt_o | output | ROWS | Right outputs of the last column |
| phase_o | output | 1 | Colour evaluated by the next step (0 = even x+y) |
| cycle_o | output | CNT_W | Completed two-phase cycles |

## Verification
A program write and a step can land in the same clock. When that step evaluates the written cell, the outcome shows whether the old program or the new one was used. The bench sets this up on purpose by aligning the phase so that cell (0,0) is evaluated while it is being rewritten. During a long pseudo-random sweep it also lets writes and steps coincide at random. A reference model in the bench applies every write after the evaluation of the same cycle. Each step is judged by comparing all four edge output vectors, `phase_o` and `cycle_o` against that model.

// File: rtl/lut_grid_pkg.sv
package lut_grid_pkg;
  localparam int unsigned DIR_UP = 0;
  localparam int unsigned DIR_RT = 1;
  localparam int unsigned DIR_DN = 2;
  localparam int unsigned DIR_LF = 3;

  typedef logic [3:0]  nib_t;
  typedef logic [63:0] prog_t;

  localparam prog_t PROG_PASS = 64'hFB73EA62D951C840;
  localparam prog_t PROG_ZERO = 64'h0;

  function automatic nib_t lut_pick(prog_t p, nib_t sel);
    return p[{sel, 2'b00} +: 4];
  endfunction
endpackage

// File: rtl/lut_grid_ctrl.sv
module lut_grid_ctrl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic             phase_o,
  output logic [CNT_W-1:0] cycle_o,
  output logic             eval_even_o,
  output logic             eval_odd_o
);
  logic             phase_q;
  logic [CNT_W-1:0] cycle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      cycle_q <= '0;
    end else if (step_i) begin
      phase_q <= ~phase_q;
      if (phase_q) cycle_q <= cycle_q + 1'b1;
    end
  end

  assign eval_even_o = step_i & ~phase_q;
  assign eval_odd_o  = step_i &  phase_q;
  assign phase_o     = phase_q;
  assign cycle_o     = cycle_q;
endmodule

// File: rtl/lut_grid_cell.sv
module lut_grid_cell
  import lut_grid_pkg::*;
#(
  parameter bit PASS_DEFAULT = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  eval_i,
  input  logic  wr_i,
  input  prog_t wr_data_i,
  input  nib_t  nbr_i,
  output nib_t  out_o
);
  localparam prog_t RST_PROG = PASS_DEFAULT ? PROG_PASS : PROG_ZERO;

  prog_t prog_q;
  nib_t  out_q;

  // evaluation reads prog_q before a same-cycle write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q <= RST_PROG;
      out_q  <= '0;
    end else begin
      if (eval_i) out_q  <= lut_pick(prog_q, nbr_i);
      if (wr_i)   prog_q <= wr_data_i;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/lut_grid.sv
module lut_grid
  import lut_grid_pkg::*;
#(
  parameter int unsigned COLS         = 4,
  parameter int unsigned ROWS         = 4,
  parameter int unsigned CNT_W        = 16,
  parameter bit          PASS_DEFAULT = 1'b1,
  localparam int unsigned NCELL       = COLS * ROWS,
  localparam int unsigned ADDR_W      = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              prog_we_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [63:0]       prog_data_i,
  input  logic [COLS-1:0]   edge_up_i,
  input  logic [COLS-1:0]   edge_dn_i,
  input  logic [ROWS-1:0]   edge_lf_i,
  input  logic [ROWS-1:0]   edge_rt_i,
  output logic [COLS-1:0]   edge_up_o,
  output logic [COLS-1:0]   edge_dn_o,
  output logic [ROWS-1:0]   edge_lf_o,
  output logic [ROWS-1:0]   edge_rt_o,
  output logic              phase_o,
  output logic [CNT_W-1:0]  cycle_o
);
  logic            eval_even, eval_odd;
  logic [NCELL*4-1:0] cell_out;

  lut_grid_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step_i),
    .phase_o     (phase_o),
    .cycle_o     (cycle_o),
    .eval_even_o (eval_even),
    .eval_odd_o  (eval_odd)
  );

  for (genvar y = 0; y < ROWS; y++) begin : g_row
    for (genvar x = 0; x < COLS; x++) begin : g_col
      localparam int unsigned IDX = y * COLS + x;
      nib_t nbr;
      logic wr_sel;

      if (y == 0) begin : g_up_edge
        assign nbr[DIR_UP] = edge_up_i[x];
      end else begin : g_up_cell
        assign nbr[DIR_UP] = cell_out[((y-1)*COLS+x)*4 + DIR_DN];
      end
      if (x == COLS-1) begin : g_rt_edge
        assign nbr[DIR_RT] = edge_rt_i[y];
      end else begin : g_rt_cell
        assign nbr[DIR_RT] = cell_out[(y*COLS+x+1)*4 + DIR_LF];
      end
      if (y == ROWS-1) begin : g_dn_edge
        assign nbr[DIR_DN] = edge_dn_i[x];
      end else begin : g_dn_cell
        assign nbr[DIR_DN] = cell_out[((y+1)*COLS+x)*4 + DIR_UP];
      end
      if (x == 0) begin : g_lf_edge
        assign nbr[DIR_LF] = edge_lf_i[y];
      end else begin : g_lf_cell
        assign nbr[DIR_LF] = cell_out[(y*COLS+x-1)*4 + DIR_RT];
      end

      assign wr_sel = prog_we_i && (prog_addr_i == ADDR_W'(IDX));

      lut_grid_cell #(.PASS_DEFAULT(PASS_DEFAULT)) u_cell (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .eval_i    ((((x + y) % 2) == 0) ? eval_even : eval_odd),
        .wr_i      (wr_sel),
        .wr_data_i (prog_data_i),
        .nbr_i     (nbr),
        .out_o     (cell_out[IDX*4 +: 4])
      );
    end
  end

  for (genvar x = 0; x < COLS; x++) begin : g_edge_col
    assign edge_up_o[x] = cell_out[x*4 + DIR_UP];
    assign edge_dn_o[x] = cell_out[((ROWS-1)*COLS+x)*4 + DIR_DN];
  end
  for (genvar y = 0; y < ROWS; y++) begin : g_edge_row
    assign edge_lf_o[y] = cell_out[(y*COLS)*4 + DIR_LF];
    assign edge_rt_o[y] = cell_out[(y*COLS+COLS-1)*4 + DIR_RT];
  end
endmodule

// File: rtl/lut_grid_chk.sv
module lut_grid_chk #(
  parameter int unsigned COLS  = 4,
  parameter int unsigned ROWS  = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   step_i,
  input logic                   phase_i,
  input logic [CNT_W-1:0]       cycle_i,
  input logic [COLS*ROWS*4-1:0] cells_i
);
  AST_PHASE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> phase_i != $past(phase_i)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_i) && $stable(cycle_i) && $stable(cells_i)); // R5

  AST_CYCLE_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_i) |=> cycle_i == CNT_W'($past(cycle_i) + 1'b1)); // R6

  AST_CYCLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !phase_i) |=> $stable(cycle_i)); // R6

  for (genvar y = 0; y < ROWS; y++) begin : g_r
    for (genvar x = 0; x < COLS; x++) begin : g_c
      localparam bit PAR = ((x + y) % 2) != 0;
      AST_OFF_COLOUR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && (phase_i != PAR)) |=> $stable(cells_i[(y*COLS+x)*4 +: 4])); // R4
    end
  end
endmodule

bind lut_grid lut_grid_chk #(.COLS(COLS), .ROWS(ROWS), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .step_i  (step_i),
  .phase_i (phase_o),
  .cycle_i (cycle_o),
  .cells_i (cell_out)
);

// File: tb/tb_lut_grid.sv
`timescale 1ns/1ps
module tb_lut_grid;
  localparam int COLS = 3;
  localparam int ROWS = 3;
  localparam int N    = COLS * ROWS;
  localparam int CW   = 4;
  localparam int AW   = 4;
  localparam logic [63:0] P_PASS = 64'hFB73EA62D951C840;
  localparam logic [63:0] P_REFL = 64'hFEDCBA9876543210;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [COLS-1:0] eu = '0, ed = '0;
  logic [ROWS-1:0] el = '0, er = '0;
  logic [COLS-1:0] ou, od, zu, zd;
  logic [ROWS-1:0] ol, orr, zl, zr;
  logic ph, zph;
  logic [CW-1:0] cyc, zcyc;

  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [63:0] m_prog [N];
  logic [3:0]  m_out  [N];
  bit m_phase;
  int m_cycle;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #4 clk = ~clk;

  lut_grid #(.COLS(COLS), .ROWS(ROWS), .CNT_W(CW), .PASS_DEFAULT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .prog_we_i(we),
    .prog_addr_i(addr), .prog_data_i(wdata),
    .edge_up_i(eu), .edge_dn_i(ed), .edge_lf_i(el), .edge_rt_i(er),
    .edge_up_o(ou), .edge_dn_o(od), .edge_lf_o(ol), .edge_rt_o(orr),
    .phase_o(ph), .cycle_o(cyc));

  lut_grid #(.COLS(COLS), .ROWS(ROWS), .CNT_W(CW), .PASS_DEFAULT(1'b0)) dut_zero (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .prog_we_i(1'b0),
    .prog_addr_i('0), .prog_data_i('0),
    .edge_up_i(eu), .edge_dn_i(ed), .edge_lf_i(el), .edge_rt_i(er),
    .edge_up_o(zu), .edge_dn_o(zd), .edge_lf_o(zl), .edge_rt_o(zr),
    .phase_o(zph), .cycle_o(zcyc));

  function automatic logic [63:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 7;
    seed ^= seed << 17;
    return seed;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] m_in(int x, int y);
    logic [3:0] s;
    s[0] = (y == 0)      ? eu[x] : m_out[(y-1)*COLS+x][2];
    s[1] = (x == COLS-1) ? er[y] : m_out[y*COLS+x+1][3];
    s[2] = (y == ROWS-1) ? ed[x] : m_out[(y+1)*COLS+x][0];
    s[3] = (x == 0)      ? el[y] : m_out[y*COLS+x-1][1];
    return s;
  endfunction

  task automatic model_step(bit st, bit w, int a, logic [63:0] d);
    logic [3:0] nx [N];
    if (st) begin
      for (int y = 0; y < ROWS; y++)
        for (int x = 0; x < COLS; x++) begin
          nx[y*COLS+x] = m_out[y*COLS+x];
          if (((x + y) % 2) == int'(m_phase))
            nx[y*COLS+x] = m_prog[y*COLS+x][4*m_in(x, y) +: 4];
        end
      for (int i = 0; i < N; i++) m_out[i] = nx[i];
      if (m_phase) m_cycle = (m_cycle + 1) % (1 << CW);
      m_phase = ~m_phase;
    end
    if (w && a < N) m_prog[a] = d;
  endtask

  task automatic compare(string tag);
    logic [11:0] exp, act;
    for (int x = 0; x < COLS; x++) begin
      exp[x]     = m_out[x][0];
      exp[3 + x] = m_out[(ROWS-1)*COLS+x][2];
    end
    for (int y = 0; y < ROWS; y++) begin
      exp[6 + y] = m_out[y*COLS][3];
      exp[9 + y] = m_out[y*COLS+COLS-1][1];
    end
    act = {orr, ol, od, ou};
    chk(act === exp, {tag, " edges"}, 64'(act), 64'(exp));
    chk(ph === m_phase, {tag, " phase"}, 64'(ph), 64'(m_phase));
    chk(int'(cyc) == m_cycle, {tag, " cycle"}, 64'(cyc), 64'(m_cycle));
  endtask

  task automatic run(bit st, bit w, int a, logic [63:0] d, string tag);
    @(negedge clk);
    step = st; we = w; addr = AW'(a); wdata = d;
    @(posedge clk);
    #1;
    model_step(st, w, a, d);
    step = 1'b0; we = 1'b0;
    compare(tag);
  endtask

  task automatic rnd_edges();
    logic [63:0] r;
    r = rnd();
    eu = r[2:0]; ed = r[5:3]; el = r[8:6]; er = r[11:9];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_prog[i] = P_PASS; m_out[i] = '0; end
    m_phase = 1'b0; m_cycle = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare("R7 reset");
    chk({zr, zl, zd, zu, zph, zcyc} === '0, "R7 zero reset", 64'({zr, zl, zd, zu}), 64'h0);

    // R7 / R9 pass-through default programs
    eu = 3'b101; el = 3'b011; ed = 3'b110; er = 3'b001;
    for (int i = 0; i < 8; i++) begin
      if (i == 4) begin eu = 3'b010; er = 3'b110; end
      run(1'b1, 1'b0, 0, '0, "R7/R9 pass");
    end
    chk({zr, zl, zd, zu} === '0, "R7 zero default", 64'({zr, zl, zd, zu}), 64'h0);

    // R9 reflect: load through write port (R8), then step
    for (int i = 0; i < N; i++) run(1'b0, 1'b1, i, P_REFL, "R8 load");
    for (int i = 0; i < 8; i++) begin
      rnd_edges();
      run(1'b1, 1'b0, 0, '0, "R9 reflect");
    end

    // R5: no step, moving edges and writes change nothing
    for (int i = 0; i < 6; i++) begin
      rnd_edges();
      run(1'b0, (i % 2) == 0, i, rnd(), "R5 idle");
    end

    // R8: write coinciding with the step that evaluates cell (0,0)
    if (m_phase) run(1'b1, 1'b0, 0, '0, "R8 align");
    eu = 3'b001; el = 3'b001;
    run(1'b1, 1'b1, 0, 64'h0, "R8 same-cycle write");
    for (int i = 0; i < 4; i++) run(1'b1, 1'b0, 0, '0, "R8 after write");
    for (int a = N; a < 16; a++) run(1'b0, 1'b1, a, 64'h0, "R8 out of range");
    for (int i = 0; i < 4; i++) begin
      rnd_edges();
      run(1'b1, 1'b0, 0, '0, "R8 out of range");
    end

    // R1/R2/R3/R4/R6 sweep with random programs, edges, writes, steps
    for (int i = 0; i < N; i++) run(1'b0, 1'b1, i, rnd(), "R1 load");
    for (int i = 0; i < 700; i++) begin
      logic [63:0] r;
      r = rnd();
      rnd_edges();
      run(r[40] | r[41], r[42] & r[43] & r[44], int'(r[51:48]), rnd(), "R1/R2/R3/R4/R6 sweep");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule